// File: doc/BRIEF.md
# Accumulator Execute Unit with Status Flags

This block is the execute stage of an 8-bit accumulator machine that runs 14-bit instruction words. Each cycle in which `in_valid` is high, it takes the instruction word, the working register W, the byte already read from the file register named by the instruction, and the current carry flag. One cycle later it presents an 8-bit result with its destination (W or the addressed file register), new values for the carry (C), digit carry (DC) and zero (Z) flags, a write enable for each flag, and a request to skip the next instruction.

It covers the byte-oriented register instructions, the bit set, clear and test instructions, and the literal arithmetic and logic instructions. Each instruction updates only its own subset of the flags. Subtraction reports "no borrow" on C. Rotates go through the carry. Decrement-and-skip and increment-and-skip leave Z untouched. When an instruction writes the status register and also updates flags, the flag values replace the matching bits of the written byte. The register file, program counter and fetch logic sit around this block. It has no storage for them.

Top module: `acc_exec_unit`

## Requirements
- R1: The results of an instruction accepted with `in_valid` high appear with `out_valid` high on the next cycle. Instruction bit 7 (d) selects the destination, 0 for W and 1 for the file register. Bits 6:0 appear on `f_addr`. When `out_valid` is low, no write, flag enable or skip is asserted.
- R2: Add (byte opcode 000111, literal 11111x) and subtract (byte opcode 000010 computing f−W, literal 11110x computing k−W) update C, DC and Z. On add, C is the carry out of bit 7 and DC is the carry out of bit 3. On subtract, C=1 and DC=1 mean no borrow out of bit 7 and out of bit 3 respectively. For example, 1−2 gives 0xFF with C=0.
- R3: AND (000101), IOR (000100), XOR (000110), complement (001001), increment (001010), decrement (000011), move-f (001000), clear (000001, d=1 clears f, d=0 clears W), and literal AND/IOR/XOR (111001/111000/111010) update only Z, which is 1 exactly when the result is 0x00.
- R4: Rotate left (001101) and rotate right (001100) move the byte one place through C (a 9-bit rotation) and update only C.
- R5: Swap (001110) exchanges the nibbles. Move-W-to-f (000000 with d=1) writes W to f. Bit clear (0100bb) and bit set (0101bb) rewrite the whole byte with only bit b (instruction bits 9:7) changed and always target f. None of these update any flag.
- R6: Decrement-skip-if-zero (001011) and increment-skip-if-zero (001111) write their result to the d-selected destination, assert skip exactly when the result is 0x00, and update no flag.
- R7: Bit test (0110bb skips when bit b is 0, 0111bb skips when bit b is 1) writes nothing and updates no flag.
- R8: Move-literal (1100xx) loads the 8-bit literal into W with no flag update. All literal operations target W.
- R9: When the destination is the file register at address `STATUS_ADDR` (default 0x03), each enabled flag replaces its bit of the written byte: C is bit 0, DC is bit 1 and Z is bit 2. Clearing the status register yields 0x04.
- R10: Reserved and control encodings (for example 111011xx_xxxxxx, 1101xx, 10xxxx, and 000000 with d=0) produce no write, no flag update and no skip.
- R11: A synchronous active-high reset clears `out_valid`, all writes, all flag enables and the skip request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 14 | Instruction word |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | Byte read from the addressed file register |
| c_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Results of the previous cycle's instruction |
| result | output | 8 | Result byte (status merge applied) |
| wr_en | output | 1 | Result is to be written |
| dest_file | output | 1 | 1: write to file register, 0: write to W |
| f_addr | output | 7 | File register address from the instruction |
| c_out | output | 1 | New carry value |
| dc_out | output | 1 | New digit carry value |
| z_out | output | 1 | New zero value |
| c_we | output | 1 | Carry write enable |
| dc_we | output | 1 | Digit carry write enable |
| z_we | output | 1 | Zero write enable |
| skip | output | 1 | Request to discard the next instruction |

## Verification
Every result, flag, enable and skip of this block is due exactly one clock after the edge that accepts the instruction. No output depends on a later cycle. The bench drives each instruction on a falling edge and lets the next rising edge capture it. It compares every output on the falling edge after that, then drops `in_valid` and checks that the following cycle shows no write, flag enable or skip. Flag values are compared only where the expected enable is set. The enables themselves are always compared, so an extra flag update is caught.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W  = 8;
    localparam int INSTR_W = 14;
    localparam int ADDR_W  = 7;
    localparam int BIT_W   = $clog2(DATA_W);

    // positions of the flags inside the status byte
    localparam int C_POS  = 0;
    localparam int DC_POS = 1;
    localparam int Z_POS  = 2;

    typedef enum logic [4:0] {
        OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_COM,
        OP_INC, OP_DEC, OP_MOVF, OP_PASSW, OP_PASSK, OP_CLR,
        OP_RL, OP_RR, OP_SWAP, OP_BCLR, OP_BSET, OP_BTST
    } op_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flags_t;

    typedef struct packed {
        op_e    op;
        logic   use_lit;    // second source is the literal instead of f
        logic   to_file;    // destination is the file register
        logic   wr;         // result is written
        flags_t fwe;        // per-flag update enables
        logic   skip_zero;  // skip when result is zero
        logic   test_pol;   // bit test: skip when bit equals this
    } dec_t;

    function automatic flags_t flag_set(input logic c, input logic dc, input logic z);
        flag_set = '{c: c, dc: dc, z: z};
    endfunction

    function automatic logic [DATA_W-1:0] nib_swap(input logic [DATA_W-1:0] v);
        nib_swap = {v[DATA_W/2-1:0], v[DATA_W-1:DATA_W/2]};
    endfunction

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_alu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic d_bit;
    assign d_bit = instr[7];

    always_comb begin
        dec = '{op: OP_NONE, use_lit: 1'b0, to_file: 1'b0, wr: 1'b0,
                fwe: flag_set(1'b0, 1'b0, 1'b0), skip_zero: 1'b0, test_pol: 1'b0};
        casez (instr[13:8])
            // byte-oriented group
            6'b000000: begin
                if (d_bit) begin
                    dec.op = OP_PASSW; dec.wr = 1'b1; dec.to_file = 1'b1;
                end
            end
            6'b000001: begin dec.op = OP_CLR;  dec.wr = 1'b1; dec.to_file = d_bit; dec.fwe.z = 1'b1; end
            6'b000010: begin dec.op = OP_SUB;  dec.wr = 1'b1; dec.to_file = d_bit; dec.fwe = flag_set(1'b1, 1'b1, 1'b1); end
            6'b000011: begin dec.op = OP_DEC;  dec.wr = 1'b1; dec.to_file = d_bit; dec.fwe.z = 1'b1; end
            6'b000100: begin dec.op = OP_IOR;  dec.wr = 1'b1; dec.to_file = d_bit; dec.fwe.z = 1'b1; end
            6'b000101: begin dec.op = OP_AND;  dec.wr = 1'b1; dec.to_file = d_bit; dec.fwe.z = 1'b1; end
            6'b000110: begin dec.op = OP_XOR;  dec.wr = 1'b1; dec.to_file = d_bit; dec.fwe.z = 1'b1; end
            6'b000111: begin dec.op = OP_ADD;  dec.wr = 1'b1; dec.to_file = d_bit; dec.fwe = flag_set(1'b1, 1'b1, 1'b1); end
            6'b001000: begin dec.op = OP_MOVF; dec.wr = 1'b1; dec.to_file = d_bit; dec.fwe.z = 1'b1; end
            6'b001001: begin dec.op = OP_COM;  dec.wr = 1'b1; dec.to_file = d_bit; dec.fwe.z = 1'b1; end
            6'b001010: begin dec.op = OP_INC;  dec.wr = 1'b1; dec.to_file = d_bit; dec.fwe.z = 1'b1; end
            6'b001011: begin dec.op = OP_DEC;  dec.wr = 1'b1; dec.to_file = d_bit; dec.skip_zero = 1'b1; end
            6'b001100: begin dec.op = OP_RR;   dec.wr = 1'b1; dec.to_file = d_bit; dec.fwe.c = 1'b1; end
            6'b001101: begin dec.op = OP_RL;   dec.wr = 1'b1; dec.to_file = d_bit; dec.fwe.c = 1'b1; end
            6'b001110: begin dec.op = OP_SWAP; dec.wr = 1'b1; dec.to_file = d_bit; end
            6'b001111: begin dec.op = OP_INC;  dec.wr = 1'b1; dec.to_file = d_bit; dec.skip_zero = 1'b1; end
            // bit-oriented group
            6'b0100??: begin dec.op = OP_BCLR; dec.wr = 1'b1; dec.to_file = 1'b1; end
            6'b0101??: begin dec.op = OP_BSET; dec.wr = 1'b1; dec.to_file = 1'b1; end
            6'b0110??: begin dec.op = OP_BTST; dec.test_pol = 1'b0; end
            6'b0111??: begin dec.op = OP_BTST; dec.test_pol = 1'b1; end
            // literal group, always to W
            6'b1100??: begin dec.op = OP_PASSK; dec.use_lit = 1'b1; dec.wr = 1'b1; end
            6'b111000: begin dec.op = OP_IOR; dec.use_lit = 1'b1; dec.wr = 1'b1; dec.fwe.z = 1'b1; end
            6'b111001: begin dec.op = OP_AND; dec.use_lit = 1'b1; dec.wr = 1'b1; dec.fwe.z = 1'b1; end
            6'b111010: begin dec.op = OP_XOR; dec.use_lit = 1'b1; dec.wr = 1'b1; dec.fwe.z = 1'b1; end
            6'b11110?: begin dec.op = OP_SUB; dec.use_lit = 1'b1; dec.wr = 1'b1; dec.fwe = flag_set(1'b1, 1'b1, 1'b1); end
            6'b11111?: begin dec.op = OP_ADD; dec.use_lit = 1'b1; dec.wr = 1'b1; dec.fwe = flag_set(1'b1, 1'b1, 1'b1); end
            default:   ;
        endcase
    end
endmodule

// File: rtl/acc_addsub.sv
module acc_addsub #(
    parameter int W   = 8,
    parameter int LOW = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         half_carry
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;
    logic [LOW:0] low;

    // subtraction as a + ~b + 1, so carry reads as "no borrow"
    assign b_eff = sub ? ~b : b;
    assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    assign low   = {1'b0, a[LOW-1:0]} + {1'b0, b_eff[LOW-1:0]} + {{LOW{1'b0}}, sub};

    assign sum        = full[W-1:0];
    assign carry      = full[W];
    assign half_carry = low[LOW];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  dec_t              dec,
    input  logic [DATA_W-1:0] w_val,
    input  logic [DATA_W-1:0] f_val,
    input  logic [DATA_W-1:0] lit,
    input  logic [BIT_W-1:0]  bit_sel,
    input  logic              c_cur,
    output logic [DATA_W-1:0] res,
    output flags_t            flg,
    output logic              skip_req
);
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] as_sum;
    logic              as_c, as_dc;
    logic [DATA_W-1:0] bit_mask;
    logic              res_zero;

    assign src      = dec.use_lit ? lit : f_val;
    assign bit_mask = {{(DATA_W-1){1'b0}}, 1'b1} << bit_sel;

    acc_addsub #(.W(DATA_W), .LOW(DATA_W/2)) u_addsub (
        .a          (src),
        .b          (w_val),
        .sub        (dec.op == OP_SUB),
        .sum        (as_sum),
        .carry      (as_c),
        .half_carry (as_dc)
    );

    always_comb begin
        res   = '0;
        flg.c = c_cur;
        unique case (dec.op)
            OP_ADD, OP_SUB: res = as_sum;
            OP_AND:   res = src & w_val;
            OP_IOR:   res = src | w_val;
            OP_XOR:   res = src ^ w_val;
            OP_COM:   res = ~src;
            OP_INC:   res = src + 1'b1;
            OP_DEC:   res = src - 1'b1;
            OP_MOVF:  res = src;
            OP_PASSW: res = w_val;
            OP_PASSK: res = src;
            OP_CLR:   res = '0;
            OP_RL: begin res = {src[DATA_W-2:0], c_cur}; flg.c = src[DATA_W-1]; end
            OP_RR: begin res = {c_cur, src[DATA_W-1:1]}; flg.c = src[0]; end
            OP_SWAP:  res = nib_swap(src);
            OP_BCLR:  res = src & ~bit_mask;
            OP_BSET:  res = src | bit_mask;
            default:  res = '0;
        endcase
        if (dec.op == OP_ADD || dec.op == OP_SUB) flg.c = as_c;
    end

    assign res_zero = (res == '0);
    assign flg.dc   = as_dc;
    assign flg.z    = res_zero;

    always_comb begin
        skip_req = 1'b0;
        if (dec.op == OP_BTST)
            skip_req = ((src & bit_mask) != '0) == dec.test_pol;
        else if (dec.skip_zero)
            skip_req = res_zero;
    end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import acc_alu_pkg::*;
#(
    parameter logic [6:0] STATUS_ADDR = 7'h03
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [13:0] instr,
    input  logic [7:0]  w_in,
    input  logic [7:0]  f_in,
    input  logic        c_in,
    output logic        out_valid,
    output logic [7:0]  result,
    output logic        wr_en,
    output logic        dest_file,
    output logic [6:0]  f_addr,
    output logic        c_out,
    output logic        dc_out,
    output logic        z_out,
    output logic        c_we,
    output logic        dc_we,
    output logic        z_we,
    output logic        skip
);
    dec_t              dec;
    logic [DATA_W-1:0] alu_res;
    flags_t            alu_flg;
    logic              alu_skip;
    logic              hits_status;
    logic [DATA_W-1:0] merged;

    acc_decode u_dec (.instr(instr), .dec(dec));

    acc_alu u_alu (
        .dec      (dec),
        .w_val    (w_in),
        .f_val    (f_in),
        .lit      (instr[DATA_W-1:0]),
        .bit_sel  (instr[ADDR_W+BIT_W-1:ADDR_W]),
        .c_cur    (c_in),
        .res      (alu_res),
        .flg      (alu_flg),
        .skip_req (alu_skip)
    );

    // flag updates win over the data written into the status register
    assign hits_status = dec.wr && dec.to_file && (instr[ADDR_W-1:0] == STATUS_ADDR);

    always_comb begin
        merged = alu_res;
        if (hits_status) begin
            if (dec.fwe.c)  merged[C_POS]  = alu_flg.c;
            if (dec.fwe.dc) merged[DC_POS] = alu_flg.dc;
            if (dec.fwe.z)  merged[Z_POS]  = alu_flg.z;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            wr_en     <= 1'b0;
            dest_file <= 1'b0;
            f_addr    <= '0;
            c_out     <= 1'b0;
            dc_out    <= 1'b0;
            z_out     <= 1'b0;
            c_we      <= 1'b0;
            dc_we     <= 1'b0;
            z_we      <= 1'b0;
            skip      <= 1'b0;
        end else begin
            out_valid <= in_valid;
            result    <= merged;
            dest_file <= dec.to_file;
            f_addr    <= instr[ADDR_W-1:0];
            c_out     <= alu_flg.c;
            dc_out    <= alu_flg.dc;
            z_out     <= alu_flg.z;
            wr_en     <= in_valid && dec.wr;
            c_we      <= in_valid && dec.fwe.c;
            dc_we     <= in_valid && dec.fwe.dc;
            z_we      <= in_valid && dec.fwe.z;
            skip      <= in_valid && alu_skip;
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(wr_en || skip || c_we || dc_we || z_we));

    // R3
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && z_we && !(wr_en && dest_file && f_addr == STATUS_ADDR))
            |-> (z_out == (result == 8'h00)));

    // R9
    status_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && wr_en && dest_file && f_addr == STATUS_ADDR && z_we)
            |-> (result[Z_POS] == z_out));

    // R6
    skip_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && skip && wr_en) |-> (result == 8'h00 && !z_we && !c_we));
endmodule

// File: tb/acc_exec_unit_tb.sv
`timescale 1ns/1ps
module acc_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [13:0] instr;
    logic [7:0]  w_in, f_in;
    logic        c_in;
    logic        out_valid, wr_en, dest_file, c_out, dc_out, z_out, c_we, dc_we, z_we, skip;
    logic [7:0]  result;
    logic [6:0]  f_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    acc_exec_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .w_in(w_in),
        .f_in(f_in), .c_in(c_in), .out_valid(out_valid), .result(result),
        .wr_en(wr_en), .dest_file(dest_file), .f_addr(f_addr), .c_out(c_out),
        .dc_out(dc_out), .z_out(z_out), .c_we(c_we), .dc_we(dc_we), .z_we(z_we),
        .skip(skip)
    );

    // we and fl are ordered {c, dc, z}; rq is the requirement number for the message
    typedef struct packed {
        logic [13:0] ins;
        logic [7:0]  w;
        logic [7:0]  f;
        logic        c;
        logic [7:0]  res;
        logic        wr;
        logic        dst;
        logic [2:0]  we;
        logic [2:0]  fl;
        logic        sk;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VECS [NV] = '{
        // R2 add / subtract
        '{14'h0720, 8'h17, 8'hC2, 1'b0, 8'hD9, 1'b1, 1'b0, 3'b111, 3'b000, 1'b0, 8'd2},
        '{14'h07A0, 8'h10, 8'hF7, 1'b0, 8'h07, 1'b1, 1'b1, 3'b111, 3'b100, 1'b0, 8'd2},
        '{14'h0720, 8'h08, 8'h08, 1'b0, 8'h10, 1'b1, 1'b0, 3'b111, 3'b010, 1'b0, 8'd2},
        '{14'h0220, 8'h02, 8'h01, 1'b1, 8'hFF, 1'b1, 1'b0, 3'b111, 3'b000, 1'b0, 8'd2},
        '{14'h0220, 8'h05, 8'h05, 1'b0, 8'h00, 1'b1, 1'b0, 3'b111, 3'b111, 1'b0, 8'd2},
        '{14'h0220, 8'h01, 8'h10, 1'b0, 8'h0F, 1'b1, 1'b0, 3'b111, 3'b100, 1'b0, 8'd2},
        // R3 Z-only group
        '{14'h05A0, 8'h17, 8'hC2, 1'b0, 8'h02, 1'b1, 1'b1, 3'b001, 3'b000, 1'b0, 8'd3},
        '{14'h0420, 8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 3'b001, 3'b001, 1'b0, 8'd3},
        '{14'h0620, 8'hFF, 8'h0F, 1'b0, 8'hF0, 1'b1, 1'b0, 3'b001, 3'b000, 1'b0, 8'd3},
        '{14'h09A0, 8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b1, 3'b001, 3'b001, 1'b0, 8'd3},
        '{14'h03A0, 8'h00, 8'h01, 1'b0, 8'h00, 1'b1, 1'b1, 3'b001, 3'b001, 1'b0, 8'd3},
        '{14'h0AA0, 8'h00, 8'hFF, 1'b1, 8'h00, 1'b1, 1'b1, 3'b001, 3'b001, 1'b0, 8'd3},
        '{14'h0820, 8'h55, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 3'b001, 3'b001, 1'b0, 8'd3},
        '{14'h01A0, 8'h33, 8'h5A, 1'b0, 8'h00, 1'b1, 1'b1, 3'b001, 3'b001, 1'b0, 8'd3},
        '{14'h0100, 8'h5A, 8'h11, 1'b0, 8'h00, 1'b1, 1'b0, 3'b001, 3'b001, 1'b0, 8'd3},
        '{14'h3800, 8'h00, 8'h77, 1'b0, 8'h00, 1'b1, 1'b0, 3'b001, 3'b001, 1'b0, 8'd3},
        '{14'h395F, 8'hA3, 8'h00, 1'b0, 8'h03, 1'b1, 1'b0, 3'b001, 3'b000, 1'b0, 8'd3},
        '{14'h3AFF, 8'hFF, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 3'b001, 3'b001, 1'b0, 8'd3},
        // R4 rotates
        '{14'h0D20, 8'h00, 8'hE6, 1'b0, 8'hCC, 1'b1, 1'b0, 3'b100, 3'b100, 1'b0, 8'd4},
        '{14'h0CA0, 8'h00, 8'h3A, 1'b1, 8'h9D, 1'b1, 1'b1, 3'b100, 3'b000, 1'b0, 8'd4},
        '{14'h0CA0, 8'h00, 8'h39, 1'b0, 8'h1C, 1'b1, 1'b1, 3'b100, 3'b100, 1'b0, 8'd4},
        // R5 no-flag group
        '{14'h0EA0, 8'h00, 8'hA5, 1'b0, 8'h5A, 1'b1, 1'b1, 3'b000, 3'b000, 1'b0, 8'd5},
        '{14'h00A0, 8'h4F, 8'hFF, 1'b0, 8'h4F, 1'b1, 1'b1, 3'b000, 3'b000, 1'b0, 8'd5},
        '{14'h13A0, 8'h00, 8'hC7, 1'b0, 8'h47, 1'b1, 1'b1, 3'b000, 3'b000, 1'b0, 8'd5},
        '{14'h17A0, 8'h00, 8'h0A, 1'b0, 8'h8A, 1'b1, 1'b1, 3'b000, 3'b000, 1'b0, 8'd5},
        // R6 decrement / increment and skip
        '{14'h0BA0, 8'h00, 8'h01, 1'b0, 8'h00, 1'b1, 1'b1, 3'b000, 3'b000, 1'b1, 8'd6},
        '{14'h0BA0, 8'h00, 8'h02, 1'b0, 8'h01, 1'b1, 1'b1, 3'b000, 3'b000, 1'b0, 8'd6},
        '{14'h0F20, 8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b0, 3'b000, 3'b000, 1'b1, 8'd6},
        // R7 bit tests
        '{14'h1A20, 8'h00, 8'hEF, 1'b0, 8'h00, 1'b0, 1'b0, 3'b000, 3'b000, 1'b1, 8'd7},
        '{14'h1A20, 8'h00, 8'h10, 1'b0, 8'h00, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 8'd7},
        '{14'h1E20, 8'h00, 8'h10, 1'b0, 8'h00, 1'b0, 1'b0, 3'b000, 3'b000, 1'b1, 8'd7},
        '{14'h1E20, 8'h00, 8'hEF, 1'b0, 8'h00, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 8'd7},
        // R8 literal forms
        '{14'h3E15, 8'h10, 8'h00, 1'b0, 8'h25, 1'b1, 1'b0, 3'b111, 3'b000, 1'b0, 8'd8},
        '{14'h3C01, 8'h02, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b0, 3'b111, 3'b000, 1'b0, 8'd8},
        '{14'h305A, 8'h10, 8'h00, 1'b0, 8'h5A, 1'b1, 1'b0, 3'b000, 3'b000, 1'b0, 8'd8},
        // R9 status register as destination
        '{14'h0183, 8'h00, 8'hFF, 1'b0, 8'h04, 1'b1, 1'b1, 3'b001, 3'b001, 1'b0, 8'd9},
        '{14'h0783, 8'h01, 8'hFF, 1'b0, 8'h07, 1'b1, 1'b1, 3'b111, 3'b111, 1'b0, 8'd9},
        '{14'h0583, 8'h03, 8'h0F, 1'b0, 8'h03, 1'b1, 1'b1, 3'b001, 3'b000, 1'b0, 8'd9},
        '{14'h0083, 8'hFF, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b1, 3'b000, 3'b000, 1'b0, 8'd9},
        // R10 reserved / control
        '{14'h3B00, 8'h12, 8'h34, 1'b1, 8'h00, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 8'd10},
        '{14'h2800, 8'h12, 8'h34, 1'b1, 8'h00, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 8'd10}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive on a falling edge, rising edge captures, compare on the next falling edge
    task automatic apply(input vec_t v);
        logic [2:0] we_a, fl_a, fl_m;
        logic       res_ok;
        string      rn;
        instr = v.ins; w_in = v.w; f_in = v.f; c_in = v.c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        we_a  = {c_we, dc_we, z_we};
        fl_a  = {c_out, dc_out, z_out} & v.we;
        fl_m  = v.fl & v.we;
        res_ok = !v.wr || (result == v.res);
        rn = $sformatf("R%0d", v.rq);
        check(out_valid && (wr_en == v.wr) && res_ok && (!v.wr || dest_file == v.dst)
              && (we_a == v.we) && (fl_a == fl_m) && (skip == v.sk) && (f_addr == v.ins[6:0]),
              rn, $sformatf("instr %h {valid,wr,dst,res,we,fl,skip}", v.ins),
              {7'd0, out_valid, wr_en, dest_file, result, we_a, fl_a, skip, 3'd0},
              {7'd0, 1'b1, v.wr, v.wr ? v.dst : dest_file, v.wr ? v.res : result, v.we, fl_m, v.sk, 3'd0});
        // R1: idle cycle after the strobe carries nothing
        @(negedge clk);
        check(!out_valid && !wr_en && !skip && !c_we && !dc_we && !z_we, "R1",
              "idle outputs", {27'd0, out_valid, wr_en, skip, c_we, z_we}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        rst = 1'b1; in_valid = 1'b1; instr = 14'h0720; w_in = 8'h01; f_in = 8'h01; c_in = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset holds everything clear even with a valid instruction present
        check(!out_valid && !wr_en && !skip && !c_we && !dc_we && !z_we, "R11",
              "reset state", {27'd0, out_valid, wr_en, skip, c_we, z_we}, 32'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) apply(VECS[i]);

        // R1: destination follows d on an address equal to status with d=0 (no merge to W)
        instr = 14'h0703; w_in = 8'h01; f_in = 8'hFF; c_in = 1'b0; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        check(out_valid && wr_en && !dest_file && result == 8'h00 && z_out && c_out,
              "R1", "d=0 to W with status address", {24'd0, result}, 32'h00);

        // R10: move-w-to-f form with d=0 and a return-with-literal encoding do nothing
        instr = 14'h0008; in_valid = 1'b1;
        @(negedge clk);
        check(out_valid && !wr_en && !skip && !c_we && !dc_we && !z_we, "R10",
              "control word 0x0008", {27'd0, out_valid, wr_en, skip, c_we, z_we}, 32'h10);
        instr = 14'h3455;
        @(negedge clk); in_valid = 1'b0;
        check(out_valid && !wr_en && !skip && !c_we && !dc_we && !z_we, "R10",
              "literal-return word", {27'd0, out_valid, wr_en, skip, c_we, z_we}, 32'h10);

        // R1: back-to-back instructions each land one cycle after acceptance
        instr = 14'h305A; in_valid = 1'b1;
        @(negedge clk);
        check(out_valid && result == 8'h5A, "R1", "first of pair", {24'd0, result}, 32'h5A);
        instr = 14'h30A5;
        @(negedge clk); in_valid = 1'b0;
        check(out_valid && result == 8'hA5, "R1", "second of pair", {24'd0, result}, 32'hA5);

        // R11: reset in mid-stream clears a pending result
        instr = 14'h0BA0; f_in = 8'h01; in_valid = 1'b1;
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check(!out_valid && !wr_en && !skip, "R11", "reset mid-stream",
              {29'd0, out_valid, wr_en, skip}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule